// File: doc/BRIEF.md
# Dual-Output Level Interrupt Controller with Software Source

This block collects up to 32 level-sensitive interrupt sources and turns them into two processor request lines: a normal request and a fast request. Each request line has its own enable mask. Software changes a mask only through a pair of write-only words: one sets the bits written as one, the other clears them. A read-modify-write sequence is never needed.

Source 0 has a second driver. Software can raise a held latch and lower it again, and the latch is ORed with hardware input 0. This lets firmware post an interrupt to itself on the same path as a hardware event. Software reads the masked status, the raw level and the mask for each request line. Read data is registered. Both request outputs are registered, so each follows a change in a source or a mask after exactly one clock. The block does no prioritisation, no vectoring and no edge capture.

The register bus is word-addressed, with single-cycle write and read strobes. It has no back-pressure: every access completes in the cycle it is presented. Read data appears on the clock edge that samples the read strobe and is held until the next read.

Top module: `icu_dual_irq`

## Requirements
- R1: `irq_o` is high one clock after any bit of (level AND normal mask) is set, and low one clock after none is set.
- R2: `fiq_o` follows (level AND fast mask) with the same one-clock timing as R1.
- R3: During and after reset, both masks and the software latch are zero, `irq_o`, `fiq_o` and `bus_rdata_o` are zero, and no source can assert an output until a mask bit is set.
- R4: A write to word 2 ORs the write data into the normal mask. A write to word 3 clears every normal-mask bit that is one in the write data. Other mask bits keep their value.
- R5: A write to word 10 ORs the write data into the fast mask. A write to word 11 clears the fast-mask bits written as one.
- R6: Level bit 0 is hardware source 0 ORed with the software latch. A write to word 4 with data bit 0 at one raises the latch. A write to word 5 with data bit 0 at one lowers it. Writes to these words with data bit 0 at zero leave the latch unchanged, whatever the other data bits are.
- R7: Reads of word 0 and word 8 return level AND normal mask and level AND fast mask, in that order. Words 1 and 9 both return the raw 32-bit level. Word 2 returns the normal mask and word 10 returns the fast mask.
- R8: A read of word 4 returns level bit 0 in data bit 0, with data bits 31..1 at zero.
- R9: Writes to words 0, 1, 8 and 9, and to any unmapped word, change no mask and no latch.
- R10: Reads of words 3, 5 and 11, and of any unmapped word, return zero.
- R11: `bus_rdata_o` is loaded on the clock edge that samples `bus_rd_i` and is held unchanged while `bus_rd_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_i | input | 32 | Level-sensitive interrupt sources, bit n is source n |
| bus_wr_i | input | 1 | Write strobe, one access per cycle |
| bus_rd_i | input | 1 | Read strobe, one access per cycle |
| bus_addr_i | input | 6 | Word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Normal interrupt request, registered |
| fiq_o | output | 1 | Fast interrupt request, registered |

## Verification
The assertions assume that the read and write strobes are never both high in one cycle. If they were, a read would return the value from before the write, and the hold check on the read data would not apply. They also assume that `src_i` changes only between clock edges. The stimulus drives every bus access and every source change on the falling edge and raises only one strobe at a time. It then samples the request outputs and the read data on the following falling edge, which is after the one rising edge that registers them.

// File: rtl/icu_pkg.sv
package icu_pkg;
  localparam int unsigned NUM_CH = 2;        // channel 0 = normal, 1 = fast
  localparam int unsigned CH_STRIDE = 8;     // word distance between channel banks
  // word offsets inside one channel bank
  localparam int unsigned OFS_STAT = 0;
  localparam int unsigned OFS_RAW  = 1;
  localparam int unsigned OFS_SET  = 2;
  localparam int unsigned OFS_CLR  = 3;
  // software latch words
  localparam int unsigned W_SOFT_SET = 4;
  localparam int unsigned W_SOFT_CLR = 5;

  typedef enum logic [2:0] {
    RK_NONE, RK_STAT, RK_RAW, RK_MASK, RK_SOFT
  } rd_kind_e;

  typedef struct packed {
    rd_kind_e kind;
    logic     ch;
  } rd_sel_t;
endpackage

// File: rtl/icu_decode.sv
module icu_decode
  import icu_pkg::*;
#(
  parameter int unsigned AW = 6
) (
  input  logic              wr_i,
  input  logic [AW-1:0]     addr_i,
  output logic [NUM_CH-1:0] mask_set_o,
  output logic [NUM_CH-1:0] mask_clr_o,
  output logic              soft_set_o,
  output logic              soft_clr_o,
  output rd_sel_t           rd_sel_o
);
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_wr
    localparam logic [AW-1:0] A_SET = AW'(ch * CH_STRIDE + OFS_SET);
    localparam logic [AW-1:0] A_CLR = AW'(ch * CH_STRIDE + OFS_CLR);
    assign mask_set_o[ch] = wr_i && (addr_i == A_SET);
    assign mask_clr_o[ch] = wr_i && (addr_i == A_CLR);
  end

  assign soft_set_o = wr_i && (addr_i == AW'(W_SOFT_SET));
  assign soft_clr_o = wr_i && (addr_i == AW'(W_SOFT_CLR));

  always_comb begin
    rd_sel_o = '{kind: RK_NONE, ch: 1'b0};
    for (int ch = 0; ch < NUM_CH; ch++) begin
      if (addr_i == AW'(ch * CH_STRIDE + OFS_STAT)) rd_sel_o = '{kind: RK_STAT, ch: ch[0]};
      if (addr_i == AW'(ch * CH_STRIDE + OFS_RAW))  rd_sel_o = '{kind: RK_RAW,  ch: ch[0]};
      if (addr_i == AW'(ch * CH_STRIDE + OFS_SET))  rd_sel_o = '{kind: RK_MASK, ch: ch[0]};
    end
    if (addr_i == AW'(W_SOFT_SET)) rd_sel_o = '{kind: RK_SOFT, ch: 1'b0};
  end
endmodule

// File: rtl/icu_mask_reg.sv
module icu_mask_reg #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_stb_i,
  input  logic         clr_stb_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] mask_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         mask_o <= '0;
    else if (clr_stb_i) mask_o <= mask_o & ~wdata_i;
    else if (set_stb_i) mask_o <= mask_o | wdata_i;
  end

  // R4 / R5: set word ORs bits in
  a_r4_mask_set: assert property (@(posedge clk) disable iff (!rst_n)
    (set_stb_i && !clr_stb_i) |=> ((mask_o & $past(wdata_i)) == $past(wdata_i)));
  // R4 / R5: clear word removes bits written as one
  a_r4_mask_clr: assert property (@(posedge clk) disable iff (!rst_n)
    clr_stb_i |=> ((mask_o & $past(wdata_i)) == '0));
  // R4 / R5: unwritten bits keep their value
  a_r4_mask_keep: assert property (@(posedge clk) disable iff (!rst_n)
    set_stb_i |=> ((mask_o & ~$past(wdata_i)) == ($past(mask_o) & ~$past(wdata_i))));
  // R9: no strobe, no change
  a_r9_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_stb_i && !clr_stb_i) |=> $stable(mask_o));
endmodule

// File: rtl/icu_soft_latch.sv
module icu_soft_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_stb_i,
  input  logic clr_stb_i,
  input  logic bit0_i,
  output logic soft_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    soft_o <= 1'b0;
    else if (clr_stb_i && bit0_i)  soft_o <= 1'b0;
    else if (set_stb_i && bit0_i)  soft_o <= 1'b1;
  end

  a_r6_soft_raise: assert property (@(posedge clk) disable iff (!rst_n)
    (set_stb_i && bit0_i) |=> soft_o);
  a_r6_soft_lower: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_stb_i && bit0_i) |=> !soft_o);
  a_r6_soft_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    !bit0_i |=> $stable(soft_o));
endmodule

// File: rtl/icu_out_stage.sv
module icu_out_stage #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] level_i,
  input  logic [W-1:0] mask_i,
  output logic         req_o
);
  logic any_w;
  assign any_w = |(level_i & mask_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_o <= 1'b0;
    else        req_o <= any_w;
  end
endmodule

// File: rtl/icu_dual_irq.sv
module icu_dual_irq
  import icu_pkg::*;
#(
  parameter int unsigned NSRC = 32,
  parameter int unsigned AW   = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_i,
  input  logic            bus_wr_i,
  input  logic            bus_rd_i,
  input  logic [AW-1:0]   bus_addr_i,
  input  logic [NSRC-1:0] bus_wdata_i,
  output logic [NSRC-1:0] bus_rdata_o,
  output logic            irq_o,
  output logic            fiq_o
);
  logic [NUM_CH-1:0] mask_set, mask_clr, req;
  logic              soft_set, soft_clr, soft_q;
  rd_sel_t           rd_sel;
  logic [NSRC-1:0]   mask_q [NUM_CH];
  logic [NSRC-1:0]   level_w, rd_next;

  icu_decode #(.AW(AW)) u_dec (
    .wr_i(bus_wr_i), .addr_i(bus_addr_i),
    .mask_set_o(mask_set), .mask_clr_o(mask_clr),
    .soft_set_o(soft_set), .soft_clr_o(soft_clr),
    .rd_sel_o(rd_sel)
  );

  icu_soft_latch u_soft (
    .clk(clk), .rst_n(rst_n), .set_stb_i(soft_set), .clr_stb_i(soft_clr),
    .bit0_i(bus_wdata_i[0]), .soft_o(soft_q)
  );

  assign level_w = src_i | {{(NSRC-1){1'b0}}, soft_q};

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    icu_mask_reg #(.W(NSRC)) u_mask (
      .clk(clk), .rst_n(rst_n),
      .set_stb_i(mask_set[ch]), .clr_stb_i(mask_clr[ch]),
      .wdata_i(bus_wdata_i), .mask_o(mask_q[ch])
    );
    icu_out_stage #(.W(NSRC)) u_out (
      .clk(clk), .rst_n(rst_n), .level_i(level_w), .mask_i(mask_q[ch]),
      .req_o(req[ch])
    );
  end

  assign irq_o = req[0];
  assign fiq_o = req[1];

  always_comb begin
    unique case (rd_sel.kind)
      RK_STAT: rd_next = level_w & mask_q[rd_sel.ch];
      RK_RAW:  rd_next = level_w;
      RK_MASK: rd_next = mask_q[rd_sel.ch];
      RK_SOFT: rd_next = {{(NSRC-1){1'b0}}, level_w[0]};
      default: rd_next = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        bus_rdata_o <= '0;
    else if (bus_rd_i) bus_rdata_o <= rd_next;
  end

  a_r1_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (|(level_w & mask_q[0])) |=> irq_o);
  a_r1_irq_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(level_w & mask_q[0])) |=> !irq_o);
  a_r2_fiq_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (|(level_w & mask_q[1])) |=> fiq_o);
  a_r2_fiq_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(level_w & mask_q[1])) |=> !fiq_o);
  a_r6_level0: assert property (@(posedge clk) disable iff (!rst_n)
    (src_i[0] || soft_q) |-> level_w[0]);
  a_r10_dead_words: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd_i && (bus_addr_i == AW'(3) || bus_addr_i == AW'(5) || bus_addr_i == AW'(11)))
    |=> (bus_rdata_o == '0));
  a_r11_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd_i |=> $stable(bus_rdata_o));
  a_r3_quiet_masks: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q[0] == '0 && mask_q[1] == '0) |=> (!irq_o && !fiq_o));
endmodule

// File: tb/icu_dual_irq_tb.sv
module icu_dual_irq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, fiq;

  always #4 clk = ~clk;

  icu_dual_irq u_dut (
    .clk(clk), .rst_n(rst_n), .src_i(src), .bus_wr_i(bus_wr), .bus_rd_i(bus_rd),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .irq_o(irq), .fiq_o(fiq)
  );

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [31:0] m_irq = '0, m_fiq = '0;
  bit m_soft = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  function automatic logic [31:0] lvl();
    return src | {31'b0, m_soft};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; addr = a[5:0]; wdata = d;
    @(negedge clk); bus_wr = 1'b0;
    case (a)
      2:  m_irq |= d;
      3:  m_irq &= ~d;
      10: m_fiq |= d;
      11: m_fiq &= ~d;
      4:  if (d[0]) m_soft = 1'b1;
      5:  if (d[0]) m_soft = 1'b0;
      default: ;
    endcase
  endtask

  // driver: pushes the expected read value, monitor compares
  task automatic rd(int a, logic [31:0] exp, string tag);
    @(negedge clk); bus_rd = 1'b1; addr = a[5:0];
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk); bus_rd = 1'b0;
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      if (bus_rd) begin
        @(negedge clk);
        chk(tag_q.pop_front(), rdata, exp_q.pop_front());
      end
    end
  end

  task automatic chk_out(string tag);
    @(negedge clk);
    chk({tag, " irq"}, {31'b0, irq}, {31'b0, |(lvl() & m_irq)});
    chk({tag, " fiq"}, {31'b0, fiq}, {31'b0, |(lvl() & m_fiq)});
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin : stim
    src = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    chk("R3 reset irq", {31'b0, irq}, 32'h0);
    chk("R3 reset fiq", {31'b0, fiq}, 32'h0);
    chk("R3 reset rdata", rdata, 32'h0);
    rst_n = 1'b1;
    chk_out("R3 no mask after reset");
    rd(2, 32'h0, "R3 irq mask reset");
    rd(10, 32'h0, "R3 fiq mask reset");
    rd(1, 32'hFFFF_FFFF, "R7 raw level");

    // R4 normal mask set/clear
    wr(2, 32'h0000_00F0);
    rd(2, m_irq, "R4 set word");
    wr(2, 32'h0000_0F00);
    rd(2, 32'h0000_0FF0, "R4 set ORs");
    chk_out("R1 enabled source");
    wr(3, 32'h0000_00F0);
    rd(2, 32'h0000_0F00, "R4 clear word");
    src = 32'h1234_5678;
    rd(0, 32'h1234_5678 & 32'h0F00, "R7 irq masked status");

    // R1 timing over source patterns
    @(negedge clk); src = 32'h0;          chk_out("R1 no source");
    @(negedge clk); src = 32'h0000_0100;  chk_out("R1 single source");
    @(negedge clk); src = 32'h0000_0001;  chk_out("R1 masked source");

    // R5 / R2 fast mask
    wr(10, 32'h8000_0001);
    rd(10, 32'h8000_0001, "R5 set word");
    wr(11, 32'h0000_0001);
    rd(10, 32'h8000_0000, "R5 clear word");
    @(negedge clk); src = 32'h8000_0000;  chk_out("R2 fast only");
    rd(8, 32'h8000_0000, "R7 fiq masked status");
    rd(9, 32'h8000_0000, "R7 raw via word 9");

    // R6 / R8 software source 0
    @(negedge clk); src = 32'h0;
    wr(4, 32'hFFFF_FFFE);
    rd(4, 32'h0, "R6 set with bit0 low ignored");
    wr(4, 32'h1);
    rd(4, 32'h1, "R8 soft raised");
    rd(1, 32'h1, "R6 level bit0 from latch");
    wr(2, 32'h1);
    chk_out("R6 soft drives irq");
    wr(5, 32'hFFFF_FFFE);
    rd(4, 32'h1, "R6 clear with bit0 low ignored");
    wr(5, 32'h1);
    rd(4, 32'h0, "R6 soft lowered");
    chk_out("R6 irq drops");
    @(negedge clk); src = 32'h1;
    rd(4, 32'h1, "R6 hardware source 0");
    @(negedge clk); src = 32'hFFFF_FFFE;
    rd(4, 32'h0, "R8 upper bits hidden");

    // R9 rejected writes
    wr(0, 32'hFFFF_FFFF); wr(1, 32'hFFFF_FFFF); wr(8, 32'hFFFF_FFFF);
    wr(9, 32'hFFFF_FFFF); wr(6, 32'hFFFF_FFFF); wr(63, 32'hFFFF_FFFF);
    rd(2, m_irq, "R9 irq mask unchanged");
    rd(10, m_fiq, "R9 fiq mask unchanged");
    rd(1, lvl(), "R9 latch unchanged");

    // R10 dead reads
    rd(3, 32'h0, "R10 word 3");
    rd(5, 32'h0, "R10 word 5");
    rd(11, 32'h0, "R10 word 11");
    rd(7, 32'h0, "R10 word 7");
    rd(63, 32'h0, "R10 word 63");

    // R11 hold
    rd(1, 32'hFFFF_FFFE, "R11 load");
    @(negedge clk); src = 32'h5;
    repeat (3) @(negedge clk);
    chk("R11 hold", rdata, 32'hFFFF_FFFE);
    chk_out("R1 final");

    repeat (3) @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule